// File: doc/BRIEF.md
# Wrapping address register unit

This unit keeps the four address pointers of a load/store datapath. Each pointer has two partners with the same number: a window register that sets how single steps wrap, and an index register that sets the stride. On a cycle with a step request, the selected pointer can be held, stepped down, stepped up, or moved by its index. Single steps stay inside an aligned window. The size of that window comes from the partner window register. So circular buffers need no software bounds checks.

A second update lane serves dual-access operations. It moves pointer 3 in the same cycle as the main lane. It either steps pointer 3 up with wrapping or adds index 3 to it. One write port loads any of the twelve registers. Every pointer can be read at all times on one flat output bus.

Top module: `addr_wrap_unit`

## Requirements
- R1: A synchronous active-high reset clears all pointers and all index registers, and sets all window registers to 0xFFFF. After reset, a down step on pointer 0 gives 0xFFFF, an up step gives plain +1, and an index move leaves the pointer unchanged.
- R2: Down step (step_op = 2'b01): when pointer AND window is zero, the pointer becomes pointer OR window. Otherwise it drops by one. Example: window 0x000F, 0x1230 becomes 0x123F.
- R3: Up step (step_op = 2'b10): a mask is formed by setting every bit at or below the highest set bit of the window. When pointer AND mask equals the mask, the pointer becomes pointer XOR window. Otherwise it rises by one. Example: window 0x0050, 0x10FF becomes 0x10AF.
- R4: Index move (step_op = 2'b11) adds the paired index register to the pointer modulo 2^16, with no wrapping rule.
- R5: With step_en low, or step_op = 2'b00, no pointer changes.
- R6: Only the pointer named by step_sel is affected by the main lane.
- R7: With dual_en high, pointer 3 is updated in the same cycle as the main lane. With dual_add = 0 it takes an up step under the R3 rule; with dual_add = 1 it takes an index move under the R4 rule.
- R8: When both lanes target pointer 3 in one cycle, the result of the second lane is kept.
- R9: wr_bank selects the target of the write port: 2'b00 pointer, 2'b01 window, 2'b10 index, 2'b11 nothing. A pointer write beats both lanes. Lanes in the same cycle use the window and index values from before the write.
- R10: A window of zero freezes the pointer under both single steps, because both wrap conditions always hold and OR/XOR with zero is the identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Main lane request |
| step_op | input | 2 | Main lane operation: 00 hold, 01 down, 10 up, 11 index move |
| step_sel | input | 2 | Pointer targeted by the main lane |
| dual_en | input | 1 | Second lane request on pointer 3 |
| dual_add | input | 1 | Second lane: 0 wrapping up step, 1 index move |
| wr_en | input | 1 | Register write enable |
| wr_bank | input | 2 | Write target bank: 00 pointer, 01 window, 10 index, 11 none |
| wr_sel | input | 2 | Register number for the write |
| wr_data | input | 16 | Write data |
| addr_o | output | 64 | All pointers; pointer k at bits 16k+15:16k |

## Verification
The assertions assume that every control input is at a defined 0/1 value on each rising edge after reset. The step checks assume that no pointer write hits the same register in that cycle, and that the second lane is idle when the main lane targets pointer 3. The stimulus drives every input on the falling edge and keeps it at a known value for the whole cycle. The random phase draws whole-range pointer, window and index values. It often lets the two lanes and the write port collide, and the assertions exclude exactly those cycles through their antecedents.

// File: rtl/addr_wrap_pkg.sv
package addr_wrap_pkg;

    localparam int unsigned AW = 16;

    typedef logic [AW-1:0] word_t;

    typedef enum logic [1:0] {
        STEP_HOLD  = 2'b00,
        STEP_DEC   = 2'b01,
        STEP_INC   = 2'b10,
        STEP_ADDIX = 2'b11
    } step_op_e;

    typedef enum logic [1:0] {
        BANK_ADDR  = 2'b00,
        BANK_WRAP  = 2'b01,
        BANK_INDEX = 2'b10,
        BANK_NONE  = 2'b11
    } bank_e;

    // Fill every bit below the highest set bit.
    function automatic word_t smear_down(word_t v);
        word_t m;
        m = v;
        for (int s = 1; s < int'(AW); s = s * 2)
            m = m | (m >> s);
        return m;
    endfunction

    function automatic word_t wrap_down(word_t a, word_t w);
        if ((a & w) == '0)
            return a | w;
        return a - word_t'(1);
    endfunction

    function automatic word_t wrap_up(word_t a, word_t w);
        word_t m;
        m = smear_down(w);
        if ((a & m) == m)
            return a ^ w;
        return a + word_t'(1);
    endfunction

endpackage

// File: rtl/addr_step_lane.sv
module addr_step_lane
    import addr_wrap_pkg::*;
(
    input  step_op_e op,
    input  word_t    cur,
    input  word_t    win,
    input  word_t    stride,
    output word_t    nxt
);
    always_comb begin
        unique case (op)
            STEP_DEC:   nxt = wrap_down(cur, win);
            STEP_INC:   nxt = wrap_up(cur, win);
            STEP_ADDIX: nxt = cur + stride;
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/wrap_cfg_bank.sv
module wrap_cfg_bank
    import addr_wrap_pkg::*;
#(
    parameter int NREG = 4,
    localparam int SELW = $clog2(NREG)
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [1:0]           wr_bank,
    input  logic [SELW-1:0]      wr_sel,
    input  word_t                wr_data,
    output word_t [NREG-1:0]     win_o,
    output word_t [NREG-1:0]     stride_o
);
    word_t [NREG-1:0] win_q;
    word_t [NREG-1:0] stride_q;

    for (genvar k = 0; k < NREG; k++) begin : g_cfg
        localparam logic [SELW-1:0] KSEL = SELW'(k);
        wire hit = wr_en && (wr_sel == KSEL);

        always_ff @(posedge clk) begin
            if (rst) begin
                win_q[k]    <= '1;
                stride_q[k] <= '0;
            end else begin
                if (hit && wr_bank == BANK_WRAP)  win_q[k]    <= wr_data;
                if (hit && wr_bank == BANK_INDEX) stride_q[k] <= wr_data;
            end
        end
    end

    assign win_o    = win_q;
    assign stride_o = stride_q;

    // R1: windows come out of reset all-ones, strides zero
    assert_cfg_reset_R1: assert property (@(posedge clk)
        rst |=> (win_q == {NREG{word_t'('1)}}) && (stride_q == '0));

    // R9: bank 11 changes no configuration register
    assert_bank_none_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_bank == BANK_NONE) |=> $stable(win_q) && $stable(stride_q));
endmodule

// File: rtl/addr_wrap_unit.sv
module addr_wrap_unit
    import addr_wrap_pkg::*;
#(
    parameter int NREG     = 4,
    parameter int DUAL_REG = 3,
    localparam int SELW = $clog2(NREG)
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step_en,
    input  logic [1:0]           step_op,
    input  logic [SELW-1:0]      step_sel,
    input  logic                 dual_en,
    input  logic                 dual_add,
    input  logic                 wr_en,
    input  logic [1:0]           wr_bank,
    input  logic [SELW-1:0]      wr_sel,
    input  logic [AW-1:0]        wr_data,
    output logic [NREG*AW-1:0]   addr_o
);
    localparam logic [SELW-1:0] DSEL = SELW'(DUAL_REG);

    word_t [NREG-1:0] addr_q;
    word_t [NREG-1:0] win_v;
    word_t [NREG-1:0] stride_v;

    step_op_e op_a, op_b;
    word_t    nxt_a, nxt_b;

    wrap_cfg_bank #(.NREG(NREG)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_bank  (wr_bank),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .win_o    (win_v),
        .stride_o (stride_v)
    );

    assign op_a = step_en ? step_op_e'(step_op) : STEP_HOLD;
    assign op_b = !dual_en ? STEP_HOLD : (dual_add ? STEP_ADDIX : STEP_INC);

    addr_step_lane u_lane_main (
        .op     (op_a),
        .cur    (addr_q[step_sel]),
        .win    (win_v[step_sel]),
        .stride (stride_v[step_sel]),
        .nxt    (nxt_a)
    );

    addr_step_lane u_lane_dual (
        .op     (op_b),
        .cur    (addr_q[DUAL_REG]),
        .win    (win_v[DUAL_REG]),
        .stride (stride_v[DUAL_REG]),
        .nxt    (nxt_b)
    );

    for (genvar k = 0; k < NREG; k++) begin : g_ptr
        localparam logic [SELW-1:0] KSEL = SELW'(k);
        wire wr_hit   = wr_en && wr_bank == BANK_ADDR && wr_sel == KSEL;
        wire main_hit = step_en && step_sel == KSEL;
        wire dual_hit;

        if (k == DUAL_REG) begin : g_dual
            assign dual_hit = dual_en;
        end else begin : g_nodual
            assign dual_hit = 1'b0;
        end

        // Priority: write port, then second lane, then main lane.
        always_ff @(posedge clk) begin
            if (rst)           addr_q[k] <= '0;
            else if (wr_hit)   addr_q[k] <= wr_data;
            else if (dual_hit) addr_q[k] <= nxt_b;
            else if (main_hit) addr_q[k] <= nxt_a;
        end

        assign addr_o[k*AW +: AW] = addr_q[k];
    end

    // Main lane acts alone on its target this cycle.
    wire main_solo = step_en
                  && !(wr_en && wr_bank == BANK_ADDR && wr_sel == step_sel)
                  && !(dual_en && step_sel == DSEL);
    wire dual_solo = dual_en && !(wr_en && wr_bank == BANK_ADDR && wr_sel == DSEL);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (addr_q == '0));

    assert_dec_nowrap_R2: assert property (@(posedge clk) disable iff (rst)
        (main_solo && step_op == STEP_DEC && (addr_q[step_sel] & win_v[step_sel]) != '0)
        |=> addr_q[$past(step_sel)] == $past(addr_q[step_sel]) - word_t'(1));

    assert_ix_add_R4: assert property (@(posedge clk) disable iff (rst)
        (main_solo && step_op == STEP_ADDIX)
        |=> addr_q[$past(step_sel)] == $past(addr_q[step_sel]) + $past(stride_v[step_sel]));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!(step_en && step_op != STEP_HOLD) && !dual_en && !wr_en) |=> $stable(addr_q));

    assert_dual_add_R7: assert property (@(posedge clk) disable iff (rst)
        (dual_solo && dual_add)
        |=> addr_q[DUAL_REG] == $past(addr_q[DUAL_REG]) + $past(stride_v[DUAL_REG]));

    assert_dual_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (dual_solo && step_en && step_sel == DSEL) |=> addr_q[DUAL_REG] == $past(nxt_b));

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_bank == BANK_ADDR) |=> addr_q[$past(wr_sel)] == $past(wr_data));

    assert_zero_window_R10: assert property (@(posedge clk) disable iff (rst)
        (main_solo && (step_op == STEP_DEC || step_op == STEP_INC) && win_v[step_sel] == '0)
        |=> addr_q[$past(step_sel)] == $past(addr_q[step_sel]));
endmodule

// File: tb/addr_wrap_unit_test.sv
`timescale 1ns/1ps
module addr_wrap_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_en = 0, dual_en = 0, dual_add = 0, wr_en = 0;
    logic [1:0]  step_op = 0, step_sel = 0, wr_bank = 0, wr_sel = 0;
    logic [15:0] wr_data = 0;
    logic [63:0] addr_o;

    int checks = 0;
    int fails  = 0;

    logic [15:0] am [4];
    logic [15:0] wm [4];
    logic [15:0] xm [4];

    always #2.5 clk = ~clk;

    addr_wrap_unit uut (
        .clk(clk), .rst(rst),
        .step_en(step_en), .step_op(step_op), .step_sel(step_sel),
        .dual_en(dual_en), .dual_add(dual_add),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_sel(wr_sel), .wr_data(wr_data),
        .addr_o(addr_o)
    );

    // Mask built by scanning from the top bit down.
    function automatic logic [15:0] ref_mask(logic [15:0] w);
        logic [15:0] m = '0;
        bit seen = 0;
        for (int i = 15; i >= 0; i--) begin
            if (w[i]) seen = 1;
            m[i] = seen;
        end
        return m;
    endfunction

    function automatic logic [15:0] ref_down(logic [15:0] a, logic [15:0] w);
        return ((a & w) == 16'h0) ? (a | w) : 16'(a - 16'd1);
    endfunction

    function automatic logic [15:0] ref_up(logic [15:0] a, logic [15:0] w);
        logic [15:0] m = ref_mask(w);
        return ((a & m) == m) ? (a ^ w) : 16'(a + 16'd1);
    endfunction

    task automatic check_all(input string req);
        checks++;
        for (int k = 0; k < 4; k++) begin
            if (addr_o[k*16 +: 16] !== am[k]) begin
                fails++;
                $display("FAIL %s: pointer %0d actual %h expected %h", req, k, addr_o[k*16 +: 16], am[k]);
                break;
            end
        end
    endtask

    task automatic cyc(input bit se, input logic [1:0] op, input logic [1:0] sel,
                       input bit de, input bit da,
                       input bit we, input logic [1:0] wb, input logic [1:0] ws,
                       input logic [15:0] wd, input string req);
        logic [15:0] na [4];
        for (int k = 0; k < 4; k++) na[k] = am[k];
        if (se) begin
            case (op)
                2'b01: na[sel] = ref_down(am[sel], wm[sel]);
                2'b10: na[sel] = ref_up(am[sel], wm[sel]);
                2'b11: na[sel] = 16'(am[sel] + xm[sel]);
                default: ;
            endcase
        end
        if (de) na[3] = da ? 16'(am[3] + xm[3]) : ref_up(am[3], wm[3]);
        if (we && wb == 2'b00) na[ws] = wd;
        step_en = se; step_op = op; step_sel = sel;
        dual_en = de; dual_add = da;
        wr_en = we; wr_bank = wb; wr_sel = ws; wr_data = wd;
        @(posedge clk);
        #1;
        for (int k = 0; k < 4; k++) am[k] = na[k];
        if (we && wb == 2'b01) wm[ws] = wd;
        if (we && wb == 2'b10) xm[ws] = wd;
        check_all(req);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] b, input logic [1:0] s, input logic [15:0] d, input string req);
        cyc(0, 2'b00, 2'b00, 0, 0, 1, b, s, d, req);
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int k = 0; k < 4; k++) begin am[k] = 0; wm[k] = 16'hFFFF; xm[k] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        check_all("R1 reset pointers");
        cyc(1, 2'b01, 2'd0, 0, 0, 0, 0, 0, 0, "R1 reset window all-ones down");
        cyc(1, 2'b10, 2'd2, 0, 0, 0, 0, 0, 0, "R1 reset window up");
        cyc(1, 2'b11, 2'd1, 0, 0, 0, 0, 0, 0, "R1 reset index zero");

        wr(2'b01, 2'd0, 16'h000F, "R9 window write");
        wr(2'b00, 2'd0, 16'h1230, "R9 pointer write");
        cyc(1, 2'b01, 2'd0, 0, 0, 0, 0, 0, 0, "R2 down wraps to top of window");
        cyc(1, 2'b01, 2'd0, 0, 0, 0, 0, 0, 0, "R2 plain down");
        wr(2'b00, 2'd0, 16'h123F, "R9 pointer write");
        cyc(1, 2'b10, 2'd0, 0, 0, 0, 0, 0, 0, "R3 up wraps to bottom of window");
        cyc(1, 2'b10, 2'd0, 0, 0, 0, 0, 0, 0, "R3 plain up");

        wr(2'b01, 2'd1, 16'h0050, "R9 window write");
        wr(2'b00, 2'd1, 16'h10FF, "R9 pointer write");
        cyc(1, 2'b10, 2'd1, 0, 0, 0, 0, 0, 0, "R3 uneven window up");

        wr(2'b10, 2'd2, 16'h0010, "R9 index write");
        wr(2'b00, 2'd2, 16'hFFF8, "R9 pointer write");
        cyc(1, 2'b11, 2'd2, 0, 0, 0, 0, 0, 0, "R4 index add overflows");

        cyc(1, 2'b00, 2'd2, 0, 0, 0, 0, 0, 0, "R5 hold op");
        cyc(0, 2'b01, 2'd2, 0, 0, 0, 0, 0, 0, "R5 step disabled");
        cyc(1, 2'b10, 2'd1, 0, 0, 0, 0, 0, 0, "R6 only selected pointer");

        wr(2'b10, 2'd3, 16'h0100, "R9 index write");
        cyc(1, 2'b10, 2'd0, 1, 0, 0, 0, 0, 0, "R7 dual up with main");
        cyc(1, 2'b01, 2'd2, 1, 1, 0, 0, 0, 0, "R7 dual add with main");
        cyc(1, 2'b01, 2'd3, 1, 1, 0, 0, 0, 0, "R8 dual wins on pointer 3");
        cyc(1, 2'b10, 2'd3, 1, 0, 1, 2'b00, 2'd3, 16'hBEEF, "R9 write beats both lanes");
        cyc(1, 2'b11, 2'd3, 0, 0, 1, 2'b10, 2'd3, 16'h0007, "R9 lane uses old index");
        cyc(1, 2'b11, 2'd3, 0, 0, 0, 0, 0, 0, "R9 new index in force");
        cyc(1, 2'b10, 2'd1, 0, 0, 1, 2'b11, 2'd1, 16'hDEAD, "R9 bank none ignored");
        cyc(1, 2'b11, 2'd1, 0, 0, 0, 0, 0, 0, "R9 bank none left index alone");

        wr(2'b01, 2'd2, 16'h0000, "R9 window write");
        cyc(1, 2'b01, 2'd2, 0, 0, 0, 0, 0, 0, "R10 zero window down frozen");
        cyc(1, 2'b10, 2'd2, 0, 0, 0, 0, 0, 0, "R10 zero window up frozen");

        for (int n = 0; n < 3000; n++) begin
            logic [15:0] d;
            int pick;
            pick = int'($urandom_range(0, 9));
            d = 16'($urandom);
            if (pick == 0) d = 16'h1 << $urandom_range(0, 15);
            if (pick == 1) d = (16'h1 << $urandom_range(0, 15)) - 16'd1;
            cyc(bit'($urandom_range(0, 3) != 0), 2'($urandom), 2'($urandom),
                bit'($urandom_range(0, 2) == 0), bit'($urandom),
                bit'($urandom_range(0, 3) == 0), 2'($urandom), 2'($urandom),
                d, "R2 R3 R4 R7 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule